// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits next to the SECDED checker of a DDR memory controller and keeps a record of the error events it reports. The checker raises a one-cycle pulse for each correctable or uncorrectable event. With the pulse it supplies the failing bank, row and column, the failing data word and, for corrected errors, the position of the flipped bit. The block keeps two independent logs, one for each error kind. Each log holds the details of the first event after it was last cleared, and an 8-bit saturating counter of all events since then.

Software reaches the block through a plain 32-bit register bus, with one write strobe and a combinational read port. It reads the logs and a shared statistics word, and it clears each log by setting and later releasing a clear bit in an ECC control register. Two configuration registers hold the ECC mode and the data-bus width. The `ecc_active` output reports when the pair describes the only protected setup: SECDED on a 16-bit half-width bus.

Each log is run by a three-state machine. `LOG_EMPTY` moves to `LOG_HELD` when an event arrives, and captures that event. `LOG_HELD` keeps its captured fields and only counts. Any state moves to `LOG_CLEAR` while the log's clear bit is set, and this takes priority over everything else. `LOG_CLEAR` moves back to `LOG_EMPTY` in the cycle after the clear bit is released.

Top module: `ecc_err_log_regs`

## Requirements
- R1: After reset every register reads zero and `ecc_active` is 0.
- R2: A correctable event on an empty log sets the log word at 0xC8 to valid in bit 0 and the bit position in bits [7:1]. It sets the address word at 0xCC to column [11:0], row [27:12] and bank [30:28]. The data word at 0xD0 holds the low 32 bits of the failing word. All of these are readable from the second cycle after the pulse (the capture edge plus one).
- R3: An uncorrectable event on an empty log fills 0xDC (valid in bit 0, bits [31:1] zero), 0xE0 (same address packing as R2) and 0xE4 (low 32 data bits). The bit-position input has no effect on it.
- R4: Once a log is valid, later events of the same kind leave its captured address, data and bit position unchanged.
- R5: The statistics word at 0xF0 holds the uncorrectable count in bits [7:0] and the correctable count in bits [15:8]. Each event adds one to its own kind.
- R6: A counter that has reached 255 stays at 255 when further events arrive.
- R7: Writing the control word at 0xC4 with bit 1 set clears the correctable log and count. Writing it with bit 0 set clears the uncorrectable log and count. The control bits read back as written, the clear takes effect one cycle after the write edge, and the other kind is untouched.
- R8: While a clear bit stays set, events of that kind are neither logged nor counted. After software writes zero, the next event is captured normally.
- R9: A correctable and an uncorrectable event in the same cycle are both logged and counted, each in its own registers.
- R10: The bus-width field is bits [3:2] at 0x000 and the ECC mode field is bits [2:0] at 0xF4. Both read back. `ecc_active` is 1 exactly when mode equals 4 and width equals 1.
- R11: Reads change nothing, unused bits read zero, unmapped offsets read zero, and writes to the log, address, data and statistics words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable error pulse from the checker |
| ue_evt | input | 1 | Uncorrectable error pulse from the checker |
| evt_bank | input | 3 | Bank of the failing access |
| evt_row | input | 16 | Row of the failing access |
| evt_col | input | 12 | Column of the failing access |
| evt_data | input | WORD_W (64) | Failing data word |
| evt_bitpos | input | 7 | Corrected bit position (correctable events only) |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ecc_active | output | 1 | SECDED on a half-width bus is configured |

## Verification
The bench builds the block with its default failing-word width of 64 bits. This places real content above bit 31, so the check that only the low half reaches the data registers is a meaningful one. The counters are 8 bits wide, so a burst of 300 back-to-back uncorrectable pulses reaches saturation in a few hundred cycles. The same run also shows that the correctable count beside it is undisturbed. The clear sequences drive pulses into a log while its clear bit is held and then after release, which separates the `LOG_CLEAR` and `LOG_EMPTY` behaviour at the ports.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    // Field widths fixed by the register layout
    localparam int BANK_W = 3;
    localparam int ROW_W  = 16;
    localparam int COL_W  = 12;
    localparam int POS_W  = 7;
    localparam int CNT_W  = 8;
    localparam int REG_W  = 32;
    localparam int OFS_W  = 12;
    localparam int LOC_W  = BANK_W + ROW_W + COL_W;

    // Register offsets
    localparam logic [OFS_W-1:0] OFS_BUS_CFG  = 12'h000;
    localparam logic [OFS_W-1:0] OFS_ECC_CTRL = 12'h0C4;
    localparam logic [OFS_W-1:0] OFS_CE_LOG   = 12'h0C8;
    localparam logic [OFS_W-1:0] OFS_CE_LOC   = 12'h0CC;
    localparam logic [OFS_W-1:0] OFS_CE_DATA  = 12'h0D0;
    localparam logic [OFS_W-1:0] OFS_UE_LOG   = 12'h0DC;
    localparam logic [OFS_W-1:0] OFS_UE_LOC   = 12'h0E0;
    localparam logic [OFS_W-1:0] OFS_UE_DATA  = 12'h0E4;
    localparam logic [OFS_W-1:0] OFS_STATS    = 12'h0F0;
    localparam logic [OFS_W-1:0] OFS_ECC_MODE = 12'h0F4;

    // Encodings that mark ECC as usable
    localparam logic [2:0] MODE_SECDED = 3'd4;
    localparam logic [1:0] WIDTH_HALF  = 2'd1;

    typedef enum logic [1:0] {
        LOG_EMPTY = 2'd0,
        LOG_HELD  = 2'd1,
        LOG_CLEAR = 2'd2
    } log_state_e;
endpackage

// File: rtl/ecc_log_chan.sv
module ecc_log_chan
    import ecc_log_pkg::*;
#(
    parameter int LOC_BITS  = LOC_W,
    parameter int DATA_BITS = 32,
    parameter int POS_BITS  = POS_W,
    parameter int CNT_BITS  = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_i,
    input  logic                 clr_i,
    input  logic [LOC_BITS-1:0]  loc_i,
    input  logic [DATA_BITS-1:0] data_i,
    input  logic [POS_BITS-1:0]  pos_i,
    output logic                 valid_o,
    output logic [CNT_BITS-1:0]  cnt_o,
    output logic [LOC_BITS-1:0]  loc_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic [POS_BITS-1:0]  pos_o
);
    localparam logic [CNT_BITS-1:0] CNT_MAX = '1;
    localparam logic [CNT_BITS-1:0] CNT_ONE = CNT_BITS'(1);

    log_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LOG_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions: a held clear wins over everything
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = LOG_CLEAR;
        end else begin
            unique case (state_q)
                LOG_EMPTY: if (evt_i) state_d = LOG_HELD;
                LOG_HELD:  state_d = LOG_HELD;
                LOG_CLEAR: state_d = LOG_EMPTY;
                default:   state_d = LOG_EMPTY;
            endcase
        end
    end

    // Captured fields and counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o  <= '0;
            loc_o  <= '0;
            data_o <= '0;
            pos_o  <= '0;
        end else if (state_q == LOG_EMPTY && evt_i) begin
            cnt_o  <= CNT_ONE;
            loc_o  <= loc_i;
            data_o <= data_i;
            pos_o  <= pos_i;
        end else if (state_q == LOG_HELD && evt_i && cnt_o != CNT_MAX) begin
            cnt_o  <= cnt_o + CNT_ONE;
        end
    end

    assign valid_o = (state_q == LOG_HELD);

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && evt_i && !clr_i) |=> (cnt_o == CNT_MAX));
    // R7
    clr_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0 && !valid_o));
    // R4
    first_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !clr_i) |=> ($stable(loc_o) && $stable(data_o) && $stable(pos_o)));
    // R2
    valid_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cnt_o != '0));
endmodule

// File: rtl/ecc_cfg_regs.sv
module ecc_cfg_regs
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [OFS_W-1:0] addr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [1:0]       width_o,
    output logic [2:0]       mode_o,
    output logic [1:0]       clr_o,
    output logic             ecc_active_o
);
    logic unused_wbits;
    assign unused_wbits = ^wdata_i[REG_W-1:4];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_o <= '0;
            mode_o  <= '0;
            clr_o   <= '0;
        end else if (wr_en_i) begin
            unique case (addr_i)
                OFS_BUS_CFG:  width_o <= wdata_i[3:2];
                OFS_ECC_MODE: mode_o  <= wdata_i[2:0];
                OFS_ECC_CTRL: clr_o   <= wdata_i[1:0];
                default: ;
            endcase
        end
    end

    assign ecc_active_o = (mode_o == MODE_SECDED) && (width_o == WIDTH_HALF);

    // R7
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFS_ECC_CTRL) |=> (clr_o == $past(wdata_i[1:0])));
    // R11
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(width_o) && $stable(mode_o) && $stable(clr_o)));
endmodule

// File: rtl/ecc_err_log_regs.sv
module ecc_err_log_regs
    import ecc_log_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_evt,
    input  logic              ue_evt,
    input  logic [BANK_W-1:0] evt_bank,
    input  logic [ROW_W-1:0]  evt_row,
    input  logic [COL_W-1:0]  evt_col,
    input  logic [WORD_W-1:0] evt_data,
    input  logic [POS_W-1:0]  evt_bitpos,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              ecc_active
);
    localparam int CAP_W = REG_W;

    logic [LOC_W-1:0] evt_loc;
    logic [CAP_W-1:0] evt_low;
    logic             unused_hi;

    assign evt_loc   = {evt_bank, evt_row, evt_col};
    assign evt_low   = evt_data[CAP_W-1:0];
    assign unused_hi = ^evt_data;

    logic [1:0] width_q;
    logic [2:0] mode_q;
    logic [1:0] clr_q;

    ecc_cfg_regs u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (bus_wr),
        .addr_i       (bus_addr),
        .wdata_i      (bus_wdata),
        .width_o      (width_q),
        .mode_o       (mode_q),
        .clr_o        (clr_q),
        .ecc_active_o (ecc_active)
    );

    // Index 0: uncorrectable, index 1: correctable (matches clear bits)
    logic             lg_evt   [2];
    logic [POS_W-1:0] lg_posin [2];
    logic             lg_valid [2];
    logic [CNT_W-1:0] lg_cnt   [2];
    logic [LOC_W-1:0] lg_loc   [2];
    logic [CAP_W-1:0] lg_data  [2];
    logic [POS_W-1:0] lg_pos   [2];

    assign lg_evt[0]   = ue_evt;
    assign lg_evt[1]   = ce_evt;
    assign lg_posin[0] = '0;
    assign lg_posin[1] = evt_bitpos;

    for (genvar k = 0; k < 2; k++) begin : g_log
        ecc_log_chan #(
            .LOC_BITS  (LOC_W),
            .DATA_BITS (CAP_W),
            .POS_BITS  (POS_W),
            .CNT_BITS  (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (lg_evt[k]),
            .clr_i   (clr_q[k]),
            .loc_i   (evt_loc),
            .data_i  (evt_low),
            .pos_i   (lg_posin[k]),
            .valid_o (lg_valid[k]),
            .cnt_o   (lg_cnt[k]),
            .loc_o   (lg_loc[k]),
            .data_o  (lg_data[k]),
            .pos_o   (lg_pos[k])
        );
    end

    // Read mux, no side effects
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_BUS_CFG:  bus_rdata = REG_W'({width_q, 2'b00});
            OFS_ECC_CTRL: bus_rdata = REG_W'(clr_q);
            OFS_ECC_MODE: bus_rdata = REG_W'(mode_q);
            OFS_CE_LOG:   bus_rdata = REG_W'({lg_pos[1], lg_valid[1]});
            OFS_CE_LOC:   bus_rdata = REG_W'(lg_loc[1]);
            OFS_CE_DATA:  bus_rdata = lg_data[1];
            OFS_UE_LOG:   bus_rdata = REG_W'(lg_valid[0]);
            OFS_UE_LOC:   bus_rdata = REG_W'(lg_loc[0]);
            OFS_UE_DATA:  bus_rdata = lg_data[0];
            OFS_STATS:    bus_rdata = REG_W'({lg_cnt[1], lg_cnt[0]});
            default:      bus_rdata = '0;
        endcase
    end

    logic unused_uepos;
    assign unused_uepos = ^lg_pos[0];
endmodule

// File: tb/ecc_err_log_regs_tb_top.sv
module ecc_err_log_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_evt = 1'b0, ue_evt = 1'b0;
    logic [2:0]  evt_bank = '0;
    logic [15:0] evt_row = '0;
    logic [11:0] evt_col = '0;
    logic [63:0] evt_data = '0;
    logic [6:0]  evt_bitpos = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ecc_active;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk; // 125 MHz

    ecc_err_log_regs #(.WORD_W(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
        .evt_bank(evt_bank), .evt_row(evt_row), .evt_col(evt_col),
        .evt_data(evt_data), .evt_bitpos(evt_bitpos), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ecc_active(ecc_active)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, $sformatf("reg %h", a), v, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic fire(input logic ce, input logic ue, input logic [2:0] b,
                        input logic [15:0] r, input logic [11:0] c,
                        input logic [63:0] d, input logic [6:0] p);
        @(negedge clk);
        ce_evt = ce; ue_evt = ue; evt_bank = b; evt_row = r; evt_col = c;
        evt_data = d; evt_bitpos = p;
        @(negedge clk);
        ce_evt = 1'b0; ue_evt = 1'b0;
    endtask

    task automatic t_reset();
        foreach (dut_regs[i]) rd_check("R1", dut_regs[i], 32'h0);
        check("R1", "ecc_active", 32'(ecc_active), 32'h0);
    endtask

    logic [11:0] dut_regs [10] = '{12'h000, 12'h0C4, 12'h0C8, 12'h0CC, 12'h0D0,
                                   12'h0DC, 12'h0E0, 12'h0E4, 12'h0F0, 12'h0F4};

    task automatic t_config();
        wr(12'h000, 32'hFFFF_FFF7);
        wr(12'h0F4, 32'hFFFF_FFFC);
        @(negedge clk);
        rd_check("R10", 12'h000, 32'h0000_0004);
        rd_check("R10", 12'h0F4, 32'h0000_0004);
        check("R10", "active secded/half", 32'(ecc_active), 32'h1);
        wr(12'h0F4, 32'h5);
        @(negedge clk);
        check("R10", "active mode5", 32'(ecc_active), 32'h0);
        wr(12'h0F4, 32'h4);
        wr(12'h000, 32'h0);
        @(negedge clk);
        check("R10", "active width0", 32'(ecc_active), 32'h0);
        wr(12'h000, 32'h4);
        @(negedge clk);
        check("R10", "active restored", 32'(ecc_active), 32'h1);
        rd_check("R11", 12'h100, 32'h0);
    endtask

    task automatic t_ce_capture();
        fire(1'b1, 1'b0, 3'd5, 16'hBEEF, 12'hABC, 64'h1234_5678_9ABC_DEF0, 7'h5A);
        rd_check("R2", 12'h0C8, 32'h0000_00B5);
        rd_check("R2", 12'h0CC, 32'h5BEE_FABC);
        rd_check("R2", 12'h0D0, 32'h9ABC_DEF0);
        rd_check("R5", 12'h0F0, 32'h0000_0100);
        rd_check("R2", 12'h0DC, 32'h0);
    endtask

    task automatic t_first_only();
        fire(1'b1, 1'b0, 3'd1, 16'h0101, 12'h010, 64'hFFFF_FFFF_0000_1111, 7'h03);
        rd_check("R4", 12'h0C8, 32'h0000_00B5);
        rd_check("R4", 12'h0CC, 32'h5BEE_FABC);
        rd_check("R4", 12'h0D0, 32'h9ABC_DEF0);
        rd_check("R5", 12'h0F0, 32'h0000_0200);
    endtask

    task automatic t_ue_capture();
        fire(1'b0, 1'b1, 3'd2, 16'h0001, 12'h003, 64'hFFFF_0000_CAFE_F00D, 7'h7F);
        rd_check("R3", 12'h0DC, 32'h0000_0001);
        rd_check("R3", 12'h0E0, 32'h2000_1003);
        rd_check("R3", 12'h0E4, 32'hCAFE_F00D);
        rd_check("R5", 12'h0F0, 32'h0000_0201);
    endtask

    task automatic t_readonly();
        wr(12'h0C8, 32'hFFFF_FFFF);
        wr(12'h0CC, 32'h0);
        wr(12'h0E4, 32'h0);
        wr(12'h0F0, 32'h0);
        @(negedge clk);
        rd_check("R11", 12'h0C8, 32'h0000_00B5);
        rd_check("R11", 12'h0CC, 32'h5BEE_FABC);
        rd_check("R11", 12'h0E4, 32'hCAFE_F00D);
        rd_check("R11", 12'h0F0, 32'h0000_0201);
        rd_check("R11", 12'h0F0, 32'h0000_0201);
    endtask

    task automatic t_clear_ce();
        wr(12'h0C4, 32'h2);
        @(negedge clk);
        rd_check("R7", 12'h0C4, 32'h2);
        rd_check("R7", 12'h0C8, 32'h0);
        rd_check("R7", 12'h0CC, 32'h0);
        rd_check("R7", 12'h0F0, 32'h0000_0001);
        rd_check("R7", 12'h0DC, 32'h1);
        fire(1'b1, 1'b0, 3'd7, 16'hFFFF, 12'hFFF, 64'h1, 7'h11);
        rd_check("R8", 12'h0C8, 32'h0);
        rd_check("R8", 12'h0F0, 32'h0000_0001);
        wr(12'h0C4, 32'h0);
        @(negedge clk);
        fire(1'b1, 1'b0, 3'd3, 16'h0042, 12'h007, 64'h0000_0000_0BAD_BEEF, 7'h01);
        rd_check("R8", 12'h0C8, 32'h0000_0003);
        rd_check("R8", 12'h0CC, 32'h3004_2007);
        rd_check("R8", 12'h0F0, 32'h0000_0101);
    endtask

    task automatic t_clear_ue();
        wr(12'h0C4, 32'h1);
        @(negedge clk);
        rd_check("R7", 12'h0DC, 32'h0);
        rd_check("R7", 12'h0E4, 32'h0);
        rd_check("R7", 12'h0F0, 32'h0000_0100);
        rd_check("R7", 12'h0C8, 32'h0000_0003);
        wr(12'h0C4, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_both();
        wr(12'h0C4, 32'h3);
        wr(12'h0C4, 32'h0);
        @(negedge clk);
        rd_check("R9", 12'h0F0, 32'h0);
        fire(1'b1, 1'b1, 3'd6, 16'h1234, 12'h456, 64'h0000_0000_5555_AAAA, 7'h40);
        rd_check("R9", 12'h0C8, 32'h0000_0081);
        rd_check("R9", 12'h0DC, 32'h0000_0001);
        rd_check("R9", 12'h0CC, 32'h6123_4456);
        rd_check("R9", 12'h0E0, 32'h6123_4456);
        rd_check("R9", 12'h0E4, 32'h5555_AAAA);
        rd_check("R9", 12'h0F0, 32'h0000_0101);
    endtask

    task automatic t_saturate();
        @(negedge clk);
        ue_evt = 1'b1;
        for (int i = 0; i < 300; i++) @(negedge clk);
        ue_evt = 1'b0;
        rd_check("R6", 12'h0F0, 32'h0000_01FF);
        rd_check("R6", 12'h0E0, 32'h6123_4456);
        wr(12'h0C4, 32'h1);
        @(negedge clk);
        rd_check("R7", 12'h0F0, 32'h0000_0100);
        wr(12'h0C4, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_ce_capture();
        t_first_only();
        t_ue_capture();
        t_readonly();
        t_clear_ce();
        t_clear_ue();
        t_both();
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule